// File: doc/BRIEF.md
# Raster Timing Generator

This block derives every timing signal a 640x480 panel needs from one pixel clock. It produces an active-low horizontal sync, an active-low vertical sync, an active-high data-enable, and the column and line number of the pixel currently due on the bus. A frame reader upstream uses the column and line numbers to fetch RGB data.

Every line runs in this order: sync pulse, back porch, visible pixels, front porch. Every frame runs in the same order, counted in whole lines. Phase lengths are parameters. The defaults give:

- a horizontal period of 800 clocks: sync 96, back porch 48, visible 640, front porch 16;
- a vertical period of 525 lines: sync 2, back porch 31, visible 480, front porch 12.

Deasserting the enable, or asserting the synchronous reset, parks the block. When it starts again, a frame begins at its first sync clock.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position counts 0 to 799 and then wraps to 0. `hsync_n` is low exactly for positions 0 to 95 of every line.
- R2: Positions 96 to 143 form the horizontal back porch, with `de` low. Positions 144 to 783 carry `de` high on 640 consecutive clocks. Positions 784 to 799 form the front porch, with `de` low.
- R3: `de` is high only when both the horizontal and the vertical position are inside their visible ranges. Whenever `de` is high, `hsync_n` and `vsync_n` are both high.
- R4: The line counter counts 0 to 524 and then wraps. `vsync_n` is low exactly on lines 0 and 1. Lines 2 to 32 are back porch, lines 33 to 512 are visible, and lines 513 to 524 are front porch. `de` stays low for every clock of a non-visible line.
- R5: The line counter advances only on the clock where the horizontal position wraps from its last value to 0.
- R6: Outputs `col` and `line` are valid in the same cycle as `de`. They are position minus 144 and line minus 33, so pixel (0,0) appears on the first `de`-high cycle of a frame. While `de` is low, both read 0.
- R7: While `rst` is high, `hsync_n` and `vsync_n` are 1, and `de`, `col` and `line` are 0 after the next clock edge.
- R8: While `en` is low, the outputs are parked exactly as under reset and both counters are held at 0. When `en` rises again, a new frame starts at position 0 of line 0.
- R9: The first clock edge after reset release, with `en` high, starts a frame at position (0,0). That position lies inside both sync pulses.
- R10: All outputs are registered. The outputs after clock edge k describe the position reached after k-1 edges of running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the block |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-pixel qualifier, active high |
| col | output | $clog2(H_ACT) | Pixel column during `de`, else 0 |
| line | output | $clog2(V_ACT) | Pixel line during `de`, else 0 |

## Verification
The embedded properties check the following on every cycle:

- the counters stay within their range and the horizontal counter wraps;
- the line counter holds between horizontal wraps;
- both syncs are high whenever `de` is high;
- `col` is 0 when `de` rises and is in range while `de` is high;
- a low `en` parks the outputs.

Only the bench scenarios can show that the exact phase boundaries fall at 96, 144, 784 and 800 clocks and at lines 2, 33 and 513. The same holds for the one-cycle output latency after reset release, the restart at (0,0) after a pause in the enable, and the vertical wrap. The wrap is exercised on a second, shortened-timing instance.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e h;
        phase_e v;
    } raster_phase_t;

    function automatic phase_e phase_of(input int unsigned pos,
                                        input int unsigned sync_len,
                                        input int unsigned back_len,
                                        input int unsigned act_len);
        if (pos < sync_len)
            return PH_SYNC;
        else if (pos < sync_len + back_len)
            return PH_BACK;
        else if (pos < sync_len + back_len + act_len)
            return PH_ACTIVE;
        else
            return PH_FRONT;
    endfunction

endpackage

// File: rtl/raster_axis_counter.sv
module raster_axis_counter
    import raster_timing_pkg::*;
#(
    parameter int unsigned SYNC_LEN  = 96,
    parameter int unsigned BACK_LEN  = 48,
    parameter int unsigned ACT_LEN   = 640,
    parameter int unsigned FRONT_LEN = 16,
    localparam int unsigned TOTAL    = SYNC_LEN + BACK_LEN + ACT_LEN + FRONT_LEN,
    localparam int unsigned CW       = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          wrap,
    output phase_e        phase
);
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    assign wrap  = run && step && (count == LAST);
    assign phase = phase_of(32'(count), SYNC_LEN, BACK_LEN, ACT_LEN);

    always_ff @(posedge clk) begin
        if (rst || !run)
            count <= '0;
        else if (step)
            count <= (count == LAST) ? '0 : count + 1'b1;
    end

    // R1 / R4: the count never leaves its period
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= LAST);

    // R1 / R4: a step at the last value returns the counter to zero
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (run && step && count == LAST) |=> (count == '0));

endmodule

// File: rtl/raster_out_stage.sv
module raster_out_stage
    import raster_timing_pkg::*;
#(
    parameter int unsigned HW     = 10,
    parameter int unsigned VW     = 10,
    parameter int unsigned COLW   = 10,
    parameter int unsigned LINEW  = 9,
    parameter int unsigned H_LEAD = 144,
    parameter int unsigned V_LEAD = 33,
    parameter int unsigned H_ACT  = 640
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  raster_phase_t    ph,
    input  logic [HW-1:0]    h_pos,
    input  logic [VW-1:0]    v_pos,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             de,
    output logic [COLW-1:0]  col,
    output logic [LINEW-1:0] line
);
    logic visible;
    assign visible = (ph.h == PH_ACTIVE) && (ph.v == PH_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            de      <= 1'b0;
            col     <= '0;
            line    <= '0;
        end else begin
            hsync_n <= (ph.h != PH_SYNC);
            vsync_n <= (ph.v != PH_SYNC);
            de      <= visible;
            col     <= visible ? COLW'(h_pos - HW'(H_LEAD)) : '0;
            line    <= visible ? LINEW'(v_pos - VW'(V_LEAD)) : '0;
        end
    end

    // R3: syncs are never asserted during visible pixels
    a_r3_syncs_idle_in_de: assert property (@(posedge clk) disable iff (rst)
        de |-> (hsync_n && vsync_n));

    // R6: every visible run starts at column zero
    a_r6_col_starts_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(de) |-> (col == '0));

    // R6: column stays inside the visible width
    a_r6_col_in_range: assert property (@(posedge clk) disable iff (rst)
        de |-> (32'(col) < H_ACT));

    // R8: a low enable parks the outputs one edge later
    a_r8_park_on_disable: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!de && hsync_n && vsync_n && col == '0 && line == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_timing_pkg::*;
#(
    parameter int unsigned H_SYNC  = 96,
    parameter int unsigned H_BACK  = 48,
    parameter int unsigned H_ACT   = 640,
    parameter int unsigned H_FRONT = 16,
    parameter int unsigned V_SYNC  = 2,
    parameter int unsigned V_BACK  = 31,
    parameter int unsigned V_ACT   = 480,
    parameter int unsigned V_FRONT = 12,
    localparam int unsigned COLW   = $clog2(H_ACT),
    localparam int unsigned LINEW  = $clog2(V_ACT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             de,
    output logic [COLW-1:0]  col,
    output logic [LINEW-1:0] line
);
    localparam int unsigned H_TOTAL = H_SYNC + H_BACK + H_ACT + H_FRONT;
    localparam int unsigned V_TOTAL = V_SYNC + V_BACK + V_ACT + V_FRONT;
    localparam int unsigned HW      = $clog2(H_TOTAL);
    localparam int unsigned VW      = $clog2(V_TOTAL);

    logic          [HW-1:0] h_pos;
    logic          [VW-1:0] v_pos;
    logic                   h_wrap;
    logic                   v_wrap;
    raster_phase_t          ph;

    raster_axis_counter #(
        .SYNC_LEN (H_SYNC),
        .BACK_LEN (H_BACK),
        .ACT_LEN  (H_ACT),
        .FRONT_LEN(H_FRONT)
    ) u_hcount (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .step (1'b1),
        .count(h_pos),
        .wrap (h_wrap),
        .phase(ph.h)
    );

    raster_axis_counter #(
        .SYNC_LEN (V_SYNC),
        .BACK_LEN (V_BACK),
        .ACT_LEN  (V_ACT),
        .FRONT_LEN(V_FRONT)
    ) u_vcount (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .step (h_wrap),
        .count(v_pos),
        .wrap (v_wrap),
        .phase(ph.v)
    );

    raster_out_stage #(
        .HW    (HW),
        .VW    (VW),
        .COLW  (COLW),
        .LINEW (LINEW),
        .H_LEAD(H_SYNC + H_BACK),
        .V_LEAD(V_SYNC + V_BACK),
        .H_ACT (H_ACT)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .run    (en),
        .ph     (ph),
        .h_pos  (h_pos),
        .v_pos  (v_pos),
        .hsync_n(hsync_n),
        .vsync_n(vsync_n),
        .de     (de),
        .col    (col),
        .line   (line)
    );

    // R5: the line counter holds between horizontal wraps
    a_r5_line_holds: assert property (@(posedge clk) disable iff (rst)
        (en && !h_wrap) |=> (!en || $stable(v_pos)));

    // R4: a frame wrap only happens on a line wrap
    a_r4_frame_wrap_on_line_wrap: assert property (@(posedge clk) disable iff (rst)
        v_wrap |-> h_wrap);

endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       hs, vs, de;
    logic [9:0] col;
    logic [8:0] line;

    logic       rst_s = 1'b1;
    logic       en_s  = 1'b0;
    logic       hs_s, vs_s, de_s;
    logic [1:0] col_s;
    logic [1:0] line_s;

    int vectors   = 0;
    int miscmp    = 0;
    int edges     = 0;
    bit finished  = 1'b0;

    always #2 clk = ~clk;

    raster_timing_gen i_raster_timing_gen (
        .clk(clk), .rst(rst), .en(en),
        .hsync_n(hs), .vsync_n(vs), .de(de), .col(col), .line(line)
    );

    // shortened timing: line = 2+2+4+2 = 10 clocks, frame = 1+1+3+1 = 6 lines
    raster_timing_gen #(
        .H_SYNC(2), .H_BACK(2), .H_ACT(4), .H_FRONT(2),
        .V_SYNC(1), .V_BACK(1), .V_ACT(3), .V_FRONT(1)
    ) i_raster_timing_gen_small (
        .clk(clk), .rst(rst_s), .en(en_s),
        .hsync_n(hs_s), .vsync_n(vs_s), .de(de_s), .col(col_s), .line(line_s)
    );

    typedef struct packed {
        logic [31:0] pos;
        logic        hs;
        logic        vs;
        logic        de;
        logic [9:0]  col;
        logic [8:0]  line;
    } vec_t;

    // pos = running edges minus one = line*800 + column position; sorted ascending
    localparam vec_t VECS [12] = '{
        '{32'd0,     1'b0, 1'b0, 1'b0, 10'd0,   9'd0}, // R9 R10 frame start inside both syncs
        '{32'd95,    1'b0, 1'b0, 1'b0, 10'd0,   9'd0}, // R1 last hsync clock
        '{32'd96,    1'b1, 1'b0, 1'b0, 10'd0,   9'd0}, // R2 back porch begins
        '{32'd799,   1'b1, 1'b0, 1'b0, 10'd0,   9'd0}, // R2 last front porch clock
        '{32'd800,   1'b0, 1'b0, 1'b0, 10'd0,   9'd0}, // R1 R5 line 1, new hsync
        '{32'd1600,  1'b0, 1'b1, 1'b0, 10'd0,   9'd0}, // R4 line 2, vsync ended
        '{32'd25800, 1'b1, 1'b1, 1'b0, 10'd0,   9'd0}, // R3 line 32 back porch, no de
        '{32'd26543, 1'b1, 1'b1, 1'b0, 10'd0,   9'd0}, // R2 last back porch clock of line 33
        '{32'd26544, 1'b1, 1'b1, 1'b1, 10'd0,   9'd0}, // R6 pixel (0,0)
        '{32'd27183, 1'b1, 1'b1, 1'b1, 10'd639, 9'd0}, // R2 pixel 639
        '{32'd27184, 1'b1, 1'b1, 1'b0, 10'd0,   9'd0}, // R2 front porch
        '{32'd27349, 1'b1, 1'b1, 1'b1, 10'd5,   9'd1}  // R6 pixel (5,1)
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "hsync_n idle", int'(hs), 1);
        chk(req, "vsync_n idle", int'(vs), 1);
        chk(req, "de idle", int'(de), 0);
        chk(req, "col idle", int'(col), 0);
        chk(req, "line idle", int'(line), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        miscmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R7: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R7");

        // main table
        rst = 1'b0;
        en  = 1'b1;
        edges = 0;
        for (int i = 0; i < 12; i++) begin
            while (edges < int'(VECS[i].pos) + 1) begin
                @(posedge clk);
                edges++;
            end
            @(negedge clk);
            chk("R1", "hsync_n", int'(hs), int'(VECS[i].hs));
            chk("R4", "vsync_n", int'(vs), int'(VECS[i].vs));
            chk("R3", "de", int'(de), int'(VECS[i].de));
            chk("R6", "col", int'(col), int'(VECS[i].col));
            chk("R6", "line", int'(line), int'(VECS[i].line));
        end

        // R8: enable drop mid visible region parks outputs
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R8");
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk_idle("R8");
        // R8: re-enable restarts at (0,0)
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R8", "hsync_n after restart", int'(hs), 0);
        chk("R8", "vsync_n after restart", int'(vs), 0);
        repeat (96) @(posedge clk);
        @(negedge clk);
        chk("R8", "hsync_n at pos 96 after restart", int'(hs), 1);
        chk("R8", "vsync_n at pos 96 after restart", int'(vs), 0);

        // R7: reset during run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R7");
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk_idle("R7");
        // R9 R10: first edge after release
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "hsync_n first edge", int'(hs), 0);
        chk("R9", "vsync_n first edge", int'(vs), 0);
        chk("R10", "de first edge", int'(de), 0);
        repeat (95) @(posedge clk);
        @(negedge clk);
        chk("R1", "hsync_n at pos 95", int'(hs), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "hsync_n at pos 96", int'(hs), 1);

        // R4 R5: full frames on the shortened instance, compared every cycle
        rst_s = 1'b0;
        en_s  = 1'b1;
        for (int k = 1; k <= 130; k++) begin
            int p, h, v;
            bit evis;
            @(posedge clk);
            @(negedge clk);
            p = (k - 1) % 60;
            h = p % 10;
            v = p / 10;
            evis = (h >= 4) && (h < 8) && (v >= 2) && (v < 5);
            chk("R1", "small hsync_n", int'(hs_s), (h >= 2) ? 1 : 0);
            chk("R4", "small vsync_n", int'(vs_s), (v >= 1) ? 1 : 0);
            chk("R3", "small de", int'(de_s), evis ? 1 : 0);
            chk("R6", "small col", int'(col_s), evis ? h - 4 : 0);
            chk("R5", "small line", int'(line_s), evis ? v - 2 : 0);
        end

        finish_run();
    end

endmodule